// File: doc/BRIEF.md
# Dual Reload Timer with Idle and Event Timers

This block holds two independent 8-bit down-counters and two fixed-window timers, all set through one 32-bit control word. Each down-counter picks one of three time bases (or none), counts down once per base tick while its start bit is set, and emits a one-clock expiry pulse when it reaches zero. On expiry it either reloads its programmed count and keeps running, or stops and clears its own start bit. An internal prescaler produces the base ticks; each base period is a parameter given in clock cycles.

The idle timer watches an activity input. Once enabled, it asserts a low-power-mode flag when a full selected period passes with no activity, and any activity clears the flag and restarts the wait. The event timer starts a countdown window of the selected length on each event pulse. A busy flag is high while the window runs and a one-clock done pulse marks its end.

The control word reads back through the same register layout. Two of its bits are status bits: writes to them are ignored.

Top module: `dual_reload_timer`

## Requirements
- R1: A control write loads all fields at once. Read-back places them as follows: [1:0] counter A base, [2] counter A reload, [3] counter A start, [15:8] counter A count, [5:4] counter B base, [6] counter B reload, [7] counter B start, [23:16] counter B count, [24] event enable, [25] event busy, [27:26] event period, [28] idle enable, [29] low-power flag, [31:30] idle period.
- R2: Counter A base codes are 00 none, 01 one-sixteenth second, 10 one second and 11 one minute. In auto-reload mode with count N it expires every N times the base period.
- R3: Counter B base codes are 00 none, 01 32 µs, 10 one second and 11 one minute, with the same N-times-period spacing.
- R4: A started counter decrements once per base tick. The tick that finds the count at 1 or 0 produces an expiry pulse one clock wide. The first pulse comes between (N-1)·P+1 and N·P edges after the write edge.
- R5: With reload set, an expiring counter reloads the programmed count and keeps running.
- R6: With reload clear, an expiring counter stops at count 0 and its start bit reads 0. No further pulses follow.
- R7: With base code 00 a counter holds its count and produces no expiry pulse.
- R8: With the idle timer enabled, the low-power flag rises P edges after the enabling write or after the last activity. Period codes are 00 one-sixteenth second, 01 one-eighth second, 10 one second and 11 one minute.
- R9: Activity clears the low-power flag at the next edge and restarts the idle window.
- R10: With the event timer enabled, an event sets busy for exactly P cycles, followed by a one-cycle done pulse. An event during the window restarts it. Period codes are 00 2 ms, 01 64 ms, 10 0.5 s and 11 0.25 ms.
- R11: Writes to bits 29 and 25 are ignored. Clearing an enable clears the flag that belongs to it, and events while the event timer is disabled have no effect.
- R12: After reset every output and the read-back word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| activity | input | 1 | System activity indication for the idle timer |
| event_in | input | 1 | Event trigger for the event timer |
| rd_data | output | 32 | Control word read-back including status bits |
| gp0_expire | output | 1 | Counter A expiry pulse |
| gp1_expire | output | 1 | Counter B expiry pulse |
| gp0_count | output | 8 | Counter A current count |
| gp1_count | output | 8 | Counter B current count |
| pm_mode | output | 1 | Low-power mode flag |
| evt_busy | output | 1 | Event window running |
| evt_done | output | 1 | Event window end pulse |

## Verification
A counter's first expiry falls anywhere in a window one base period wide, because the prescaler runs free. The bench therefore checks that first pulse against the window bounds. From then on it requires exact spacings of N·P edges between pulses. The idle flag is due exactly P edges after the enabling write or the last activity edge, and it is checked one cycle early as low and on time as high. The event busy flag is counted cycle by cycle, and the done pulse is checked in the cycle right after busy falls. All inputs are driven and all outputs sampled on falling edges, so each expected edge count maps to a fixed number of falling edges.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int NUM_TICK   = 4;
  localparam int TICK_32US  = 0;
  localparam int TICK_16TH  = 1;
  localparam int TICK_1S    = 2;
  localparam int TICK_1MIN  = 3;
  localparam int COUNT_W    = 8;

  typedef struct packed {
    logic [COUNT_W-1:0] count;
    logic               start;
    logic               reload;
    logic [1:0]         base;
  } gp_cfg_t;
endpackage

// File: rtl/drt_tick_div.sv
module drt_tick_div #(
  parameter int unsigned PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/drt_gp_counter.sv
module drt_gp_counter
  import drt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  gp_cfg_t            cfg_in,
  input  logic [2:0]         base_tick,
  output gp_cfg_t            cfg_o,
  output logic [COUNT_W-1:0] count_o,
  output logic               expire_o
);
  gp_cfg_t            cfg_q, cfg_d;
  logic [COUNT_W-1:0] cnt_q, cnt_d;
  logic               exp_q, exp_d;
  logic               step;

  always_comb begin
    case (cfg_q.base)
      2'd1:    step = base_tick[0];
      2'd2:    step = base_tick[1];
      2'd3:    step = base_tick[2];
      default: step = 1'b0;
    endcase
  end

  always_comb begin
    cfg_d = cfg_q;
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (cfg_wr) begin
      cfg_d = cfg_in;
      cnt_d = cfg_in.count;
    end else if (cfg_q.start && step) begin
      if (cnt_q <= COUNT_W'(1)) begin
        exp_d = 1'b1;
        if (cfg_q.reload) begin
          cnt_d = cfg_q.count;
        end else begin
          cnt_d       = '0;
          cfg_d.start = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign count_o  = cnt_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/drt_event_timer.sv
module drt_event_timer #(
  parameter int unsigned PER0 = 4,
  parameter int unsigned PER1 = 6,
  parameter int unsigned PER2 = 8,
  parameter int unsigned PER3 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       en_in,
  input  logic [1:0] sel_in,
  input  logic       trigger,
  output logic       en_o,
  output logic [1:0] sel_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int unsigned PMAX01 = (PER0 > PER1) ? PER0 : PER1;
  localparam int unsigned PMAX23 = (PER2 > PER3) ? PER2 : PER3;
  localparam int unsigned PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
  localparam int unsigned W      = $clog2(PMAX + 1);

  logic         en_q, en_d, busy_q, busy_d, done_q, done_d;
  logic [1:0]   sel_q, sel_d;
  logic [W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (sel_q)
      2'd0:    lim = W'(PER0 - 1);
      2'd1:    lim = W'(PER1 - 1);
      2'd2:    lim = W'(PER2 - 1);
      default: lim = W'(PER3 - 1);
    endcase
  end

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (cfg_wr) begin
      en_d  = en_in;
      sel_d = sel_in;
      if (!en_in) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end
    end
    if (en_d && trigger) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (en_d && busy_q) begin
      if (cnt_q >= lim) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign en_o   = en_q;
  assign sel_o  = sel_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/drt_idle_monitor.sv
module drt_idle_monitor #(
  parameter int unsigned PER0 = 5,
  parameter int unsigned PER1 = 7,
  parameter int unsigned PER2 = 9,
  parameter int unsigned PER3 = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       en_in,
  input  logic [1:0] sel_in,
  input  logic       activity,
  output logic       en_o,
  output logic [1:0] sel_o,
  output logic       mode_o
);
  localparam int unsigned PMAX01 = (PER0 > PER1) ? PER0 : PER1;
  localparam int unsigned PMAX23 = (PER2 > PER3) ? PER2 : PER3;
  localparam int unsigned PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
  localparam int unsigned W      = $clog2(PMAX + 1);

  logic         en_q, en_d, mode_q, mode_d, arm;
  logic [1:0]   sel_q, sel_d;
  logic [W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (sel_q)
      2'd0:    lim = W'(PER0 - 1);
      2'd1:    lim = W'(PER1 - 1);
      2'd2:    lim = W'(PER2 - 1);
      default: lim = W'(PER3 - 1);
    endcase
  end

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    arm    = cfg_wr && en_in && !en_q;
    if (cfg_wr) begin
      en_d  = en_in;
      sel_d = sel_in;
      if (!en_in) begin
        mode_d = 1'b0;
        cnt_d  = '0;
      end
    end
    if (en_d) begin
      if (activity || arm) begin
        mode_d = 1'b0;
        cnt_d  = '0;
      end else if (!mode_q) begin
        if (cnt_q >= lim) begin
          mode_d = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign en_o   = en_q;
  assign sel_o  = sel_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int unsigned P_32US  = 2,
  parameter int unsigned P_250US = 3,
  parameter int unsigned P_2MS   = 4,
  parameter int unsigned P_16TH  = 5,
  parameter int unsigned P_64MS  = 6,
  parameter int unsigned P_8TH   = 7,
  parameter int unsigned P_HALF  = 8,
  parameter int unsigned P_1S    = 9,
  parameter int unsigned P_1MIN  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        activity,
  input  logic        event_in,
  output logic [31:0] rd_data,
  output logic        gp0_expire,
  output logic        gp1_expire,
  output logic [7:0]  gp0_count,
  output logic [7:0]  gp1_count,
  output logic        pm_mode,
  output logic        evt_busy,
  output logic        evt_done
);
  localparam int unsigned TICK_PER [NUM_TICK] = '{P_32US, P_16TH, P_1S, P_1MIN};

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // shared free-running base ticks
  logic [NUM_TICK-1:0] tick;

  for (genvar gi = 0; gi < NUM_TICK; gi++) begin : g_div
    drt_tick_div #(.PERIOD(TICK_PER[gi])) u_div (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .tick_o (tick[gi])
    );
  end

  // two general-purpose counters, each with its own base set
  gp_cfg_t            gp_cfg_in [2];
  gp_cfg_t            gp_cfg_q  [2];
  logic [COUNT_W-1:0] gp_cnt    [2];
  logic [1:0]         gp_exp;

  assign gp_cfg_in[0] = '{count: wr_data[15:8],  start: wr_data[3],
                          reload: wr_data[2],    base: wr_data[1:0]};
  assign gp_cfg_in[1] = '{count: wr_data[23:16], start: wr_data[7],
                          reload: wr_data[6],    base: wr_data[5:4]};

  for (genvar gc = 0; gc < 2; gc++) begin : g_gp
    logic [2:0] base_set;
    if (gc == 0) begin : g_set_a
      assign base_set = {tick[TICK_1MIN], tick[TICK_1S], tick[TICK_16TH]};
    end else begin : g_set_b
      assign base_set = {tick[TICK_1MIN], tick[TICK_1S], tick[TICK_32US]};
    end
    drt_gp_counter u_cnt (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .cfg_wr    (wr_en),
      .cfg_in    (gp_cfg_in[gc]),
      .base_tick (base_set),
      .cfg_o     (gp_cfg_q[gc]),
      .count_o   (gp_cnt[gc]),
      .expire_o  (gp_exp[gc])
    );
  end

  // idle (low-power entry) timer
  logic       pm_en;
  logic [1:0] pm_sel;

  drt_idle_monitor #(
    .PER0 (P_16TH), .PER1 (P_8TH), .PER2 (P_1S), .PER3 (P_1MIN)
  ) u_idle (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cfg_wr   (wr_en),
    .en_in    (wr_data[28]),
    .sel_in   (wr_data[31:30]),
    .activity (activity),
    .en_o     (pm_en),
    .sel_o    (pm_sel),
    .mode_o   (pm_mode)
  );

  // event window timer
  logic       ev_en;
  logic [1:0] ev_sel;

  drt_event_timer #(
    .PER0 (P_2MS), .PER1 (P_64MS), .PER2 (P_HALF), .PER3 (P_250US)
  ) u_evt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cfg_wr  (wr_en),
    .en_in   (wr_data[24]),
    .sel_in  (wr_data[27:26]),
    .trigger (event_in),
    .en_o    (ev_en),
    .sel_o   (ev_sel),
    .busy_o  (evt_busy),
    .done_o  (evt_done)
  );

  assign rd_data = {pm_sel, pm_mode, pm_en, ev_sel, evt_busy, ev_en,
                    gp_cfg_q[1].count, gp_cfg_q[0].count,
                    gp_cfg_q[1].start, gp_cfg_q[1].reload, gp_cfg_q[1].base,
                    gp_cfg_q[0].start, gp_cfg_q[0].reload, gp_cfg_q[0].base};

  assign gp0_expire = gp_exp[0];
  assign gp1_expire = gp_exp[1];
  assign gp0_count  = gp_cnt[0];
  assign gp1_count  = gp_cnt[1];
endmodule

// File: rtl/drt_checker.sv
module drt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        activity,
  input logic        event_in,
  input logic [31:0] rd_data,
  input logic        gp0_expire,
  input logic        gp1_expire,
  input logic [7:0]  gp0_count,
  input logic        pm_mode,
  input logic        evt_busy,
  input logic        evt_done
);
  a_r4_gp0_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    gp0_expire |=> !gp0_expire);

  a_r4_gp1_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    gp1_expire |=> !gp1_expire);

  a_r7_gp0_base_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b00 && !wr_en) |=> ($stable(gp0_count) && !gp0_expire));

  a_r6_gp0_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (gp0_expire && !rd_data[2]) |-> !rd_data[3]);

  a_r9_activity_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !pm_mode);

  a_r11_mode_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[28] |-> !pm_mode);

  a_r11_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[24] |-> !evt_busy);

  a_r10_done_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !evt_busy);

  a_r10_event_starts_window: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && rd_data[24] && !wr_en) |=> evt_busy);
endmodule

bind dual_reload_timer drt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .activity   (activity),
  .event_in   (event_in),
  .rd_data    (rd_data),
  .gp0_expire (gp0_expire),
  .gp1_expire (gp1_expire),
  .gp0_count  (gp0_count),
  .pm_mode    (pm_mode),
  .evt_busy   (evt_busy),
  .evt_done   (evt_done)
);

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
  localparam int T32US = 2, T250US = 3, T2MS = 4, T16TH = 5, T64MS = 6;
  localparam int T8TH = 7, THALF = 8, T1S = 9, T1MIN = 11;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, activity, event_in;
  logic [31:0] wr_data, rd_data;
  logic        gp0_expire, gp1_expire, pm_mode, evt_busy, evt_done;
  logic [7:0]  gp0_count, gp1_count;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_reload_timer #(
    .P_32US(T32US), .P_250US(T250US), .P_2MS(T2MS), .P_16TH(T16TH),
    .P_64MS(T64MS), .P_8TH(T8TH), .P_HALF(THALF), .P_1S(T1S), .P_1MIN(T1MIN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .activity(activity), .event_in(event_in), .rd_data(rd_data),
    .gp0_expire(gp0_expire), .gp1_expire(gp1_expire),
    .gp0_count(gp0_count), .gp1_count(gp1_count),
    .pm_mode(pm_mode), .evt_busy(evt_busy), .evt_done(evt_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_act;
    @(negedge clk); activity = 1'b1;
    @(negedge clk); activity = 1'b0;
  endtask

  task automatic pulse_evt;
    @(negedge clk); event_in = 1'b1;
    @(negedge clk); event_in = 1'b0;
  endtask

  function automatic logic sig(input int which);
    return (which == 0) ? gp0_expire : gp1_expire;
  endfunction

  task automatic wait_pulse(input int which, input int lim, output int k);
    k = 1;
    while (!sig(which) && k < lim) begin @(negedge clk); k++; end
  endtask

  function automatic int gp_per(input int which, input int b);
    if (b == 2) return T1S;
    if (b == 3) return T1MIN;
    return (which == 0) ? T16TH : T32US;
  endfunction

  function automatic logic [31:0] gp_word(input int which, input logic [7:0] n,
                                          input logic [1:0] b, input logic st, input logic rl);
    if (which == 0) return {16'h0, n, 4'h0, st, rl, b};
    return {8'h0, n, 8'h0, st, rl, b, 4'h0};
  endfunction

  int nl [4] = '{1, 2, 3, 5};
  int pm_p [4];
  int ev_p [4];

  initial begin
    int k, m, cnt;
    logic [31:0] v;
    pm_p = '{T16TH, T8TH, T1S, T1MIN};
    ev_p = '{T2MS, T64MS, THALF, T250US};
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; activity = 1'b0; event_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(rd_data == 32'h0, "R12 rd_data", rd_data, 0);
    chk({gp0_expire, gp1_expire, pm_mode, evt_busy, evt_done} == 5'b0, "R12 flags",
        {gp0_expire, gp1_expire, pm_mode, evt_busy, evt_done}, 0);
    chk(gp0_count == 0 && gp1_count == 0, "R12 counts", gp0_count, 0);

    // R2 / R3 / R4 / R5 sweep of bases and counts with reload
    for (int w = 0; w < 2; w++) begin
      for (int b = 1; b <= 3; b++) begin
        foreach (nl[i]) begin
          int p, n;
          p = gp_per(w, b);
          n = nl[i];
          wr(gp_word(w, 8'(n), 2'(b), 1'b1, 1'b1));
          wait_pulse(w, n * p + 10, k);
          chk(k >= (n - 1) * p + 2 && k <= n * p + 1, "R4 first expiry window", k, n * p + 1);
          @(negedge clk); m = 1;
          chk(!sig(w), "R4 pulse one cycle", sig(w), 0);
          while (!sig(w) && m < n * p + 10) begin @(negedge clk); m++; end
          chk(m == n * p, (w == 0) ? "R2 R5 reload spacing" : "R3 R5 reload spacing", m, n * p);
          wr(32'h0);
        end
      end
    end

    // R6 one-shot on counter A
    wr(gp_word(0, 8'd3, 2'd1, 1'b1, 1'b0));
    wait_pulse(0, 40, k);
    chk(k >= 2 * T16TH + 2 && k <= 3 * T16TH + 1, "R6 one-shot expiry", k, 3 * T16TH + 1);
    @(negedge clk);
    chk(rd_data[3] == 1'b0, "R6 start cleared", rd_data[3], 0);
    chk(gp0_count == 8'd0, "R6 count at zero", gp0_count, 0);
    chk(rd_data[15:8] == 8'd3, "R1 programmed count kept", rd_data[15:8], 3);
    cnt = 0;
    repeat (40) begin @(negedge clk); if (gp0_expire) cnt++; end
    chk(cnt == 0, "R6 no further pulses", cnt, 0);

    // R7 base code 00 holds both counters
    wr(gp_word(0, 8'd9, 2'd0, 1'b1, 1'b1) | gp_word(1, 8'd4, 2'd0, 1'b1, 1'b1));
    cnt = 0;
    repeat (60) begin @(negedge clk); if (gp0_expire || gp1_expire) cnt++; end
    chk(cnt == 0, "R7 no pulse when base off", cnt, 0);
    chk(gp0_count == 8'd9, "R7 counter A holds", gp0_count, 9);
    chk(gp1_count == 8'd4, "R7 counter B holds", gp1_count, 4);

    // R1 / R11 field layout and read-only bits
    v = {2'b11, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'b0100_0100};
    wr(v);
    chk(rd_data == (v & 32'hDDFF_FFFF), "R1 R11 read-back layout", rd_data, v & 32'hDDFF_FFFF);
    wr(32'h0);

    // R8 / R9 idle timer for every period code
    for (int s = 0; s < 4; s++) begin
      int p;
      p = pm_p[s];
      wr({2'(s), 1'b0, 1'b1, 28'h0});
      repeat (p - 1) @(negedge clk);
      chk(pm_mode == 1'b0, "R8 mode not early", pm_mode, 0);
      @(negedge clk);
      chk(pm_mode == 1'b1 && rd_data[29], "R8 mode on time", pm_mode, 1);
      pulse_act();
      chk(pm_mode == 1'b0, "R9 activity clears mode", pm_mode, 0);
      repeat (3) begin
        repeat (p - 2) @(negedge clk);
        chk(pm_mode == 1'b0, "R9 activity keeps mode off", pm_mode, 0);
        pulse_act();
      end
      repeat (p - 1) @(negedge clk);
      chk(pm_mode == 1'b0, "R9 restart not early", pm_mode, 0);
      @(negedge clk);
      chk(pm_mode == 1'b1, "R9 restart on time", pm_mode, 1);
      wr(32'h0);
      chk(pm_mode == 1'b0, "R11 disable clears mode", pm_mode, 0);
    end

    // R10 event timer for every period code
    for (int s = 0; s < 4; s++) begin
      int p;
      p = ev_p[s];
      wr({4'h0, 2'(s), 1'b0, 1'b1, 24'h0});
      pulse_evt();
      cnt = 0;
      while (evt_busy && cnt < 100) begin cnt++; @(negedge clk); end
      chk(cnt == p, "R10 busy length", cnt, p);
      chk(evt_done == 1'b1, "R10 done pulse", evt_done, 1);
      @(negedge clk);
      chk(evt_done == 1'b0, "R10 done one cycle", evt_done, 0);
      pulse_evt();
      @(negedge clk);
      pulse_evt();
      cnt = 0;
      while (evt_busy && cnt < 100) begin cnt++; @(negedge clk); end
      chk(cnt == p, "R10 retrigger restarts window", cnt, p);
      wr(32'h0);
    end

    // R11 events ignored while disabled
    pulse_evt();
    cnt = 0;
    chk(evt_busy == 1'b0, "R11 disabled event ignored", evt_busy, 0);
    repeat (20) begin @(negedge clk); if (evt_busy || evt_done) cnt++; end
    chk(cnt == 0, "R11 no window while disabled", cnt, 0);
    chk(rd_data == 32'h0, "R11 status bits stay clear", rd_data, 0);

    report();
  end
endmodule